// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This unit produces the integer compare results used by a 32-bit soft processor. It takes two operands, a and b, and an operation code. For a signed or an unsigned compare it returns the full difference b − a. When the two operands disagree in their top bit, the top bit of that difference is replaced so that it gives the correct ordering. A byte-search operation scans the byte lanes, starting from the most significant one. It reports a 1-based lane number for the first lane where both operands hold the same byte.

A carry helper computes the carry out of a + b + carry-in for add-with-carry sequences. Every result is captured into an output register on a one-cycle start strobe. The captured carry is presented beside the result, and a valid strobe marks the cycle in which the new result can be read. The output register holds its value until the next start.

Top module: `cmpu_core`

## Requirements
- R1: While reset is high on a clock edge, result, carry and valid are all cleared to zero. Reset is synchronous and active high.
- R2: A start sampled high on a clock edge loads the register with the outcome of the operands, operation and carry-in present at that edge. The new values appear right after that edge, and valid is high for that one cycle only. Starts on consecutive edges give valid on consecutive cycles.
- R3: With start low, result and carry keep their previous values and valid stays low, whatever the other inputs do.
- R4: The operation code selects the function: 2'b00 signed compare, 2'b01 unsigned compare, 2'b10 byte search, 2'b11 carry only.
- R5: Both compare operations return b − a modulo 2^32 when bit 31 of a equals bit 31 of b.
- R6: In a signed compare where bit 31 of a and bit 31 of b differ, result bits 30:0 equal those of b − a, and result bit 31 equals bit 31 of b.
- R7: In an unsigned compare where bit 31 of a and bit 31 of b differ, result bits 30:0 equal those of b − a, and result bit 31 equals bit 31 of a.
- R8: Byte search compares the two operands one byte lane at a time. Lane 1 is bits 31:24 and lane 4 is bits 7:0. The result is the number of the lowest-numbered lane whose bytes are equal, zero-extended to 32 bits.
- R9: Byte search returns 0 when no lane holds equal bytes.
- R10: The carry output is loaded on every start, for any operation code, with the carry out of the 33-bit sum a + b + cin. For code 2'b11 the result is that carry in bit 0 with all other bits zero.
- R11: When b is all ones and cin is 1, the carry is 1 for every value of a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load the output register this edge |
| op_i | input | 2 | Operation code (see R4) |
| opa_i | input | 32 | Operand a |
| opb_i | input | 32 | Operand b |
| cin_i | input | 1 | Carry in for the carry helper |
| result_o | output | 32 | Registered result |
| carry_o | output | 1 | Registered carry out of a + b + cin |
| valid_o | output | 1 | High for the cycle after each start |

## Verification
A wrong patch decision in the subtract path shows up only in bit 31, and only when the operand signs differ. A wrong priority in the lane scan shows up only when several lanes match at once. The bench therefore drives operands that mix signs and operands with several matching lanes. Every fault reaches the ports in the cycle after the start that exposes it, because there is no deeper state than the output register. A stuck or leaking load enable shows up as a result that changes while start is low, or as a valid pulse that appears without a start. Both are checked on every idle cycle.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;

    localparam int WORD_W  = 32;
    localparam int LANE_W  = 8;

    typedef enum logic [1:0] {
        OP_CMP_S  = 2'b00,
        OP_CMP_U  = 2'b01,
        OP_BYTE   = 2'b10,
        OP_CARRY  = 2'b11
    } op_e;

    // Number of lanes and the width of a 1-based lane index (0 = no match).
    function automatic int lane_count(input int word_w, input int lane_w);
        return word_w / lane_w;
    endfunction

    function automatic int index_width(input int lanes);
        return $clog2(lanes + 1);
    endfunction

endpackage

// File: rtl/cmpu_subtract.sv
module cmpu_subtract #(
    parameter int W = cmpu_pkg::WORD_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         signed_i,
    output logic [W-1:0] diff_o
);
    logic [W-1:0] raw;
    logic         sign_split;

    always_comb begin
        raw        = b_i + ~a_i + {{(W-1){1'b0}}, 1'b1};
        sign_split = a_i[W-1] ^ b_i[W-1];
        diff_o     = raw;
        if (sign_split) begin
            diff_o[W-1] = signed_i ? b_i[W-1] : a_i[W-1];
        end
    end
endmodule

// File: rtl/cmpu_byte_scan.sv
module cmpu_byte_scan #(
    parameter int W      = cmpu_pkg::WORD_W,
    parameter int LW     = cmpu_pkg::LANE_W,
    parameter int LANES  = cmpu_pkg::lane_count(W, LW),
    parameter int IDX_W  = cmpu_pkg::index_width(LANES)
) (
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    output logic [IDX_W-1:0] hit_idx_o
);
    logic [LANES-1:0] lane_eq;

    // lane k counts from the most significant byte
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HI = W - 1 - k * LW;
        assign lane_eq[k] = (a_i[HI -: LW] == b_i[HI -: LW]);
    end

    always_comb begin
        hit_idx_o = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (lane_eq[k]) begin
                hit_idx_o = IDX_W'(k + 1);
            end
        end
    end
endmodule

// File: rtl/cmpu_carry.sv
module cmpu_carry #(
    parameter int W = cmpu_pkg::WORD_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic         cout_o
);
    logic [W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        cout_o   = wide_sum[W];
    end
endmodule

// File: rtl/cmpu_core.sv
module cmpu_core
    import cmpu_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int LW = LANE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         cin_i,
    output logic [W-1:0] result_o,
    output logic         carry_o,
    output logic         valid_o
);
    localparam int LANES = lane_count(W, LW);
    localparam int IDX_W = index_width(LANES);

    op_e              op;
    logic [W-1:0]     diff;
    logic [IDX_W-1:0] hit_idx;
    logic             cout;
    logic [W-1:0]     next_result;

    assign op = op_e'(op_i);

    cmpu_subtract #(.W(W)) u_sub (
        .a_i      (opa_i),
        .b_i      (opb_i),
        .signed_i (op == OP_CMP_S),
        .diff_o   (diff)
    );

    cmpu_byte_scan #(.W(W), .LW(LW), .LANES(LANES), .IDX_W(IDX_W)) u_scan (
        .a_i       (opa_i),
        .b_i       (opb_i),
        .hit_idx_o (hit_idx)
    );

    cmpu_carry #(.W(W)) u_carry (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .cin_i  (cin_i),
        .cout_o (cout)
    );

    always_comb begin
        unique case (op)
            OP_CMP_S, OP_CMP_U: next_result = diff;
            OP_BYTE:            next_result = {{(W-IDX_W){1'b0}}, hit_idx};
            OP_CARRY:           next_result = {{(W-1){1'b0}}, cout};
            default:            next_result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            carry_o  <= 1'b0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= start_i;
            if (start_i) begin
                result_o <= next_result;
                carry_o  <= cout;
            end
        end
    end

    // R1: reset clears the output register
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (result_o == '0 && !carry_o && !valid_o));

    // R2: a start produces exactly one valid in the next cycle
    a_r2_start_valid: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o);

    // R2, R3: valid never appears without a start
    a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !valid_o);

    // R3: outputs hold while idle
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(result_o) && $stable(carry_o)));

    // R8: byte search never reports a lane beyond the last one
    a_r8_lane_range: assert property (@(posedge clk) disable iff (rst)
        (start_i && op == OP_BYTE) |=> (result_o <= W'(LANES)));

    // R10: carry-only result uses bit 0 alone and mirrors the carry output
    a_r10_carry_only: assert property (@(posedge clk) disable iff (rst)
        (start_i && op == OP_CARRY) |=> (result_o == {{(W-1){1'b0}}, carry_o}));

    // R5: equal operands compare to zero
    a_r5_equal_zero: assert property (@(posedge clk) disable iff (rst)
        (start_i && !op_i[1] && opa_i == opb_i) |=> (result_o == '0));

endmodule

// File: tb/cmpu_core_test.sv
`timescale 1ns/1ps
module cmpu_core_test;

    typedef struct {
        logic [31:0] res;
        logic        cy;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        cin_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o;
    logic        valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    cmpu_core uut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .cin_i(cin_i),
        .result_o(result_o), .carry_o(carry_o), .valid_o(valid_o)
    );

    function automatic logic ref_carry(logic [31:0] a, logic [31:0] b, logic c);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b} + {32'd0, c};
        return s[32];
    endfunction

    function automatic logic [31:0] ref_result(logic [1:0] op, logic [31:0] a,
                                               logic [31:0] b, logic c);
        logic [31:0] d;
        d = b - a;
        case (op)
            2'b00: if (a[31] != b[31]) d[31] = b[31];
            2'b01: if (a[31] != b[31]) d[31] = a[31];
            2'b10: begin
                d = 32'd0;
                for (int n = 4; n >= 1; n--)
                    if (a[39-8*n -: 8] == b[39-8*n -: 8]) d = n;
            end
            default: d = {31'd0, ref_carry(a, b, c)};
        endcase
        return d;
    endfunction

    task automatic check(string tag, logic [32:0] act, logic [32:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one start with its expectation pushed to the scoreboard
    task automatic issue(string tag, logic [1:0] op, logic [31:0] a,
                         logic [31:0] b, logic c);
        exp_t e;
        e.res = ref_result(op, a, b, c);
        e.cy  = ref_carry(a, b, c);
        e.tag = tag;
        sb.push_back(e);
        op_i = op; opa_i = a; opb_i = b; cin_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // monitor: every valid cycle pops and compares one item
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            if (sb.size() == 0) begin
                check("R2 unexpected valid", 33'd1, 33'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {carry_o, result_o}, {e.cy, e.res});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", {valid_o, carry_o, result_o}, 33'd0);
        rst = 1'b0;
        @(negedge clk);

        issue("R5 signed same sign", 2'b00, 32'd5, 32'd3, 1'b0);
        issue("R5 unsigned same sign", 2'b01, 32'h8000_0010, 32'h8000_0001, 1'b0);
        issue("R6 signed a neg b pos", 2'b00, 32'h8000_0000, 32'd1, 1'b0);
        issue("R6 signed a pos b neg", 2'b00, 32'd7, 32'hFFFF_FFF0, 1'b0);
        issue("R7 unsigned a neg b pos", 2'b01, 32'h8000_0000, 32'd1, 1'b0);
        issue("R7 unsigned a pos b neg", 2'b01, 32'd7, 32'hFFFF_FFF0, 1'b0);
        issue("R8 lane 1 wins", 2'b10, 32'h1122_3344, 32'h11AA_33BB, 1'b0);
        issue("R8 lane 2", 2'b10, 32'h0022_3344, 32'hFF22_FF44, 1'b0);
        issue("R8 lane 4 only", 2'b10, 32'h0102_0304, 32'hA0B0_C004, 1'b0);
        issue("R9 no lane", 2'b10, 32'h0102_0304, 32'h1020_3040, 1'b0);
        issue("R10 carry op overflow", 2'b11, 32'd1, 32'hFFFF_FFFF, 1'b0);
        issue("R11 all ones with cin", 2'b11, 32'd0, 32'hFFFF_FFFF, 1'b1);
        issue("R10 carry op no carry", 2'b11, 32'd0, 32'hFFFF_FFFE, 1'b1);
        issue("R4 R10 carry beside compare", 2'b00, 32'hFFFF_0000, 32'h0001_0000, 1'b0);
        @(negedge clk);

        // R3: idle with changing inputs, outputs must hold and valid stay low
        begin
            logic [32:0] held;
            held = {carry_o, result_o};
            for (int k = 0; k < 4; k++) begin
                op_i = 2'(k); opa_i = 32'h1357_9BDF * (k + 1);
                opb_i = ~opa_i; cin_i = k[0];
                @(negedge clk);
                check("R3 hold while idle", {valid_o, carry_o, result_o}, {1'b0, held});
            end
        end

        issue("R2 single then idle", 2'b01, 32'd1, 32'd2, 1'b0);
        check("R2 valid one cycle", {32'd0, valid_o}, 33'd1);
        @(negedge clk);
        check("R2 valid drops", {32'd0, valid_o}, 33'd0);

        repeat (2) @(negedge clk);
        check("R2 scoreboard drained", 33'(sb.size()), 33'd0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule